// File: doc/BRIEF.md
# Configurable Base Address Register Window

This block holds one base address register of a configuration header together with the comparator that claims bus addresses falling inside its window. Each instance is fixed at build time as one of three kinds: an I/O window, a 32-bit memory window, or a 64-bit memory window. A 64-bit window occupies the register slot given by its slot parameter and also the slot after it. The second slot carries address bits 63:32 and every bit of it is writable.

Configuration software reaches the register through a dword-wide port. A write takes effect on the next clock edge. A read is combinational on the slot index. To find the window size, software writes all ones to the lower slot and reads the value back. Every address bit below the window size reads as zero, so the lowest bit that reads as one gives the size. Type bits are read-only constants. In use, the block compares each incoming bus address and its space type against the programmed base. The hit output is asserted only while the matching decode enable is on.

Top module: `bar_window`

## Requirements
- R1: In the lower slot, bit 0 reads 1 for an I/O window and 0 for either memory window, whatever is written to it.
- R2: In the lower slot of a memory window, bits 2:1 read 00 for the 32-bit kind and 10 for the 64-bit kind, and bit 3 reads the PREFETCH parameter. In an I/O window, bit 1 reads 0.
- R3: Lower-slot address bits below the window size read as zero and ignore writes. Writing 0xFFFFFFFF reads back the size mask ORed with the type bits. The size is at least 4 bytes for I/O and at least 16 bytes for memory.
- R4: For the 64-bit kind, slot SLOT+1 reads and writes all 32 bits as address bits 63:32. For the other kinds that slot is not owned.
- R5: A slot the instance does not own reads as zero, and writes to it change neither the readback nor the decode.
- R6: After reset, every writable bit is zero.
- R7: hit is asserted only while io_en is 1 (I/O kind) or mem_en is 1 (memory kinds).
- R8: hit is asserted only when bus_is_io equals 1 for the I/O kind, or equals 0 for the memory kinds.
- R9: Address match rules by kind. I/O: bits 31:size must equal the base. 32-bit memory: bits 31:size must equal the base and bits 63:32 must be zero. 64-bit memory: bits 63:size must equal the base.
- R10: A write is visible in the readback from the following cycle on. hit follows bus_addr in the same cycle, using the registered base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_slot | input | 3 | Register slot index (0 to 5) for read and write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the addressed slot, zero if the slot is not owned |
| bus_addr | input | 64 | Incoming bus address |
| bus_is_io | input | 1 | 1 when bus_addr is an I/O address, 0 when it is a memory address |
| io_en | input | 1 | I/O decode enable |
| mem_en | input | 1 | Memory decode enable |
| hit | output | 1 | The address falls inside this window |

## Verification
The only internal state is the stored base. A corrupted base, a wrong write mask or a bad slot decode shows up in the readback of the affected slot in the cycle after the write. It also shows up in hit for any address in the window or next to it, and because hit is combinational it appears in that same cycle. Errors in the type constants show up in the reset readback. A gating error shows up as soon as an address inside the window is presented with the wrong space or with the enable off. The bench runs three instances of different kinds side by side on a shared configuration port, so a write that leaks into another instance's slot shows up in that instance's readback.

// File: rtl/bar_pkg.sv
package bar_pkg;
    typedef enum logic [1:0] {
        KIND_IO    = 2'd0,
        KIND_MEM32 = 2'd1,
        KIND_MEM64 = 2'd2
    } bar_kind_e;

    localparam int unsigned CFG_W  = 32;
    localparam int unsigned SLOT_W = 3;
    localparam int unsigned ADDR_W = 64;
endpackage

// File: rtl/bar_store.sv
module bar_store
    import bar_pkg::*;
#(
    parameter bar_kind_e   KIND     = KIND_MEM64,
    parameter int unsigned EFF_LOG2 = 12,
    parameter bit          PREFETCH = 1'b0,
    parameter int unsigned SLOT     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic [CFG_W-1:0]  wdata,
    output logic [CFG_W-1:0]  rdata,
    output logic [ADDR_W-1:0] base
);
    localparam bit IS_IO = (KIND == KIND_IO);
    localparam bit IS_64 = (KIND == KIND_MEM64);
    localparam logic [CFG_W-1:0] LO_WMASK = 32'hFFFF_FFFF << EFF_LOG2;
    localparam logic [CFG_W-1:0] LO_CONST = IS_IO ? 32'd1
                                          : ((32'(PREFETCH) << 3) | (IS_64 ? 32'd4 : 32'd0));
    localparam logic [SLOT_W-1:0] LO_IDX = SLOT_W'(SLOT);
    localparam logic [SLOT_W-1:0] HI_IDX = SLOT_W'(SLOT + 1);

    logic [CFG_W-1:0] lo_q;
    logic [CFG_W-1:0] hi_q;
    logic             sel_lo;
    logic             sel_hi;

    assign sel_lo = (slot == LO_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= '0;
        else if (wr_en && sel_lo)
            lo_q <= wdata & LO_WMASK;
    end

    generate
        if (IS_64) begin : g_upper
            assign sel_hi = (slot == HI_IDX);
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hi_q <= '0;
                else if (wr_en && sel_hi)
                    hi_q <= wdata;
            end
        end else begin : g_no_upper
            assign sel_hi = 1'b0;
            assign hi_q   = '0;
        end
    endgenerate

    always_comb begin
        if (sel_lo)
            rdata = lo_q | LO_CONST;
        else if (sel_hi)
            rdata = hi_q;
        else
            rdata = '0;
    end

    assign base = {hi_q, lo_q};

    AST_LO_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slot == LO_IDX) |=> (base[31:0] == ($past(wdata) & LO_WMASK))) // R10
        else $error("lower slot write lost");

    AST_FOREIGN_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slot != LO_IDX && slot != HI_IDX) |=> $stable(base)) // R5
        else $error("foreign slot write changed base");

    AST_SIZE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == LO_IDX) |-> ((rdata & ~LO_WMASK) == LO_CONST)) // R3
        else $error("bits below window size not zero");
endmodule

// File: rtl/bar_match.sv
module bar_match
    import bar_pkg::*;
#(
    parameter bar_kind_e   KIND     = KIND_MEM64,
    parameter int unsigned EFF_LOG2 = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_io,
    input  logic              io_en,
    input  logic              mem_en,
    input  logic [ADDR_W-1:0] base,
    output logic              hit
);
    localparam bit IS_IO = (KIND == KIND_IO);
    localparam logic [31:0] LO_CMP = 32'hFFFF_FFFF << EFF_LOG2;
    localparam logic [ADDR_W-1:0] CMP_MASK = IS_IO ? {32'h0, LO_CMP}
                                                   : {32'hFFFF_FFFF, LO_CMP};

    logic space_ok;
    logic en_ok;
    logic addr_eq;

    generate
        if (IS_IO) begin : g_io
            assign space_ok = is_io;
            assign en_ok    = io_en;
        end else begin : g_mem
            assign space_ok = !is_io;
            assign en_ok    = mem_en;
        end
    endgenerate

    assign addr_eq = (((addr ^ base) & CMP_MASK) == '0);
    assign hit     = space_ok && en_ok && addr_eq;
endmodule

// File: rtl/bar_window.sv
module bar_window
    import bar_pkg::*;
#(
    parameter bar_kind_e   KIND      = KIND_MEM64,
    parameter int unsigned SIZE_LOG2 = 12,
    parameter bit          PREFETCH  = 1'b0,
    parameter int unsigned SLOT      = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [2:0]  cfg_slot,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [63:0] bus_addr,
    input  logic        bus_is_io,
    input  logic        io_en,
    input  logic        mem_en,
    output logic        hit
);
    localparam bit          IS_IO    = (KIND == KIND_IO);
    localparam int unsigned MIN_LOG2 = IS_IO ? 2 : 4;
    localparam int unsigned EFF_LOG2 = (SIZE_LOG2 < MIN_LOG2) ? MIN_LOG2 : SIZE_LOG2;

    logic [ADDR_W-1:0] base;

    bar_store #(
        .KIND     (KIND),
        .EFF_LOG2 (EFF_LOG2),
        .PREFETCH (PREFETCH),
        .SLOT     (SLOT)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .slot  (cfg_slot),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .base  (base)
    );

    bar_match #(
        .KIND     (KIND),
        .EFF_LOG2 (EFF_LOG2)
    ) u_match (
        .addr   (bus_addr),
        .is_io  (bus_is_io),
        .io_en  (io_en),
        .mem_en (mem_en),
        .base   (base),
        .hit    (hit)
    );

    AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (IS_IO ? io_en : mem_en)) // R7
        else $error("hit without decode enable");

    AST_HIT_SPACE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (bus_is_io == IS_IO)) // R8
        else $error("hit on wrong space");

    AST_MEM32_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && KIND == KIND_MEM32) |-> (bus_addr[63:32] == 32'h0)) // R9
        else $error("32-bit window hit above 4 GiB");

    AST_TYPE_BIT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_slot == 3'(SLOT)) |-> (cfg_rdata[0] == IS_IO)) // R1
        else $error("space bit wrong");
endmodule

// File: tb/tb_bar_window.sv
`timescale 1ns/1ps
module tb_bar_window;
    import bar_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_slot = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [63:0] bus_addr = 64'd0;
    logic        bus_is_io = 1'b0;
    logic        io_en = 1'b0;
    logic        mem_en = 1'b0;
    logic [31:0] rd64, rdio, rd32;
    logic        hit64, hitio, hit32;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference bases
    logic [63:0] mb;
    logic [31:0] ib;
    logic [31:0] sb;

    always #2.5 clk = ~clk;

    bar_window #(.KIND(KIND_MEM64), .SIZE_LOG2(12), .PREFETCH(1'b1), .SLOT(2)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_slot(cfg_slot),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd64), .bus_addr(bus_addr),
        .bus_is_io(bus_is_io), .io_en(io_en), .mem_en(mem_en), .hit(hit64));

    bar_window #(.KIND(KIND_IO), .SIZE_LOG2(5), .PREFETCH(1'b0), .SLOT(0)) dut_io (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_slot(cfg_slot),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdio), .bus_addr(bus_addr),
        .bus_is_io(bus_is_io), .io_en(io_en), .mem_en(mem_en), .hit(hitio));

    bar_window #(.KIND(KIND_MEM32), .SIZE_LOG2(16), .PREFETCH(1'b0), .SLOT(4)) dut_m32 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_slot(cfg_slot),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd32), .bus_addr(bus_addr),
        .bus_is_io(bus_is_io), .io_en(io_en), .mem_en(mem_en), .hit(hit32));

    function automatic logic [31:0] exp_rd64(input logic [2:0] s);
        if (s == 3'd2) return {mb[31:12], 12'h00C};
        if (s == 3'd3) return mb[63:32];
        return 32'd0;
    endfunction

    function automatic logic [31:0] exp_rdio(input logic [2:0] s);
        return (s == 3'd0) ? {ib[31:5], 5'h01} : 32'd0;
    endfunction

    function automatic logic [31:0] exp_rd32(input logic [2:0] s);
        return (s == 3'd4) ? {sb[31:16], 16'h0} : 32'd0;
    endfunction

    function automatic logic exp_hit64(input logic [63:0] a, input logic io, input logic me);
        return !io && me && (a[63:12] == mb[63:12]);
    endfunction

    function automatic logic exp_hitio(input logic [63:0] a, input logic io, input logic ie);
        return io && ie && (a[31:5] == ib[31:5]);
    endfunction

    function automatic logic exp_hit32(input logic [63:0] a, input logic io, input logic me);
        return !io && me && (a[63:32] == 32'd0) && (a[31:16] == sb[31:16]);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_slot  = s;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (s == 3'd2) mb[31:12] = d[31:12];
        if (s == 3'd3) mb[63:32] = d;
        if (s == 3'd0) ib[31:5]  = d[31:5];
        if (s == 3'd4) sb[31:16] = d[31:16];
    endtask

    function automatic string slot_tag(input logic [2:0] s, input logic [2:0] lo, input bit has_hi);
        if (s == lo) return "R3 lower slot";
        if (has_hi && s == lo + 3'd1) return "R4 upper slot";
        return "R5 foreign slot";
    endfunction

    task automatic check_reads(input string pre);
        for (int s = 0; s < 6; s++) begin
            cfg_slot = 3'(s);
            #1;
            check({pre, " ", slot_tag(3'(s), 3'd2, 1'b1), " m64"}, 64'(rd64), 64'(exp_rd64(3'(s))));
            check({pre, " ", slot_tag(3'(s), 3'd0, 1'b0), " io"},  64'(rdio), 64'(exp_rdio(3'(s))));
            check({pre, " ", slot_tag(3'(s), 3'd4, 1'b0), " m32"}, 64'(rd32), 64'(exp_rd32(3'(s))));
        end
    endtask

    task automatic check_hits(input string tag, input logic [63:0] a, input logic io,
                              input logic ie, input logic me);
        @(negedge clk);
        bus_addr  = a;
        bus_is_io = io;
        io_en     = ie;
        mem_en    = me;
        #1;
        check({tag, " m64"}, 64'(hit64), 64'(exp_hit64(a, io, me)));
        check({tag, " io"},  64'(hitio), 64'(exp_hitio(a, io, ie)));
        check({tag, " m32"}, 64'(hit32), 64'(exp_hit32(a, io, me)));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mb = '0; ib = '0; sb = '0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R6 reset state, R1/R2 type bits
        @(negedge clk);
        cfg_slot = 3'd2; #1; check("R6 R2 m64 reset lower", 64'(rd64), 64'h0000000C);
        cfg_slot = 3'd3; #1; check("R6 R4 m64 reset upper", 64'(rd64), 64'h0);
        cfg_slot = 3'd0; #1; check("R6 R1 io reset", 64'(rdio), 64'h1);
        cfg_slot = 3'd4; #1; check("R6 R2 m32 reset", 64'(rd32), 64'h0);

        // R3 sizing by all ones; R10 visible next cycle
        cfg_write(3'd2, 32'hFFFF_FFFF);
        cfg_slot = 3'd2; #1; check("R3 R10 m64 size mask", 64'(rd64), 64'hFFFFF00C);
        cfg_write(3'd3, 32'hFFFF_FFFF);
        cfg_slot = 3'd3; #1; check("R4 m64 upper all ones", 64'(rd64), 64'hFFFFFFFF);
        cfg_write(3'd0, 32'hFFFF_FFFF);
        cfg_slot = 3'd0; #1; check("R3 R1 io size mask", 64'(rdio), 64'hFFFFFFE1);
        cfg_write(3'd4, 32'hFFFF_FFFF);
        cfg_slot = 3'd4; #1; check("R3 R2 m32 size mask", 64'(rd32), 64'hFFFF0000);

        // R5 writes to unowned slots
        cfg_write(3'd1, 32'h1234_5678);
        cfg_write(3'd5, 32'hDEAD_BEEF);
        check_reads("R5 after foreign writes");

        // program bases
        cfg_write(3'd2, 32'h3456_7ABC);
        cfg_write(3'd3, 32'h0000_0012);
        cfg_write(3'd0, 32'h0000_C0F3);
        cfg_write(3'd4, 32'h8001_2345);
        check_reads("R10 programmed");

        // directed decode corners
        check_hits("R9 m64 inside", 64'h0000_0012_3456_7ABC, 1'b0, 1'b1, 1'b1);
        check_hits("R7 mem disabled", 64'h0000_0012_3456_7ABC, 1'b0, 1'b1, 1'b0);
        check_hits("R8 wrong space", 64'h0000_0012_3456_7ABC, 1'b1, 1'b1, 1'b1);
        check_hits("R9 m64 bit40 differs", 64'h0000_0112_3456_7ABC, 1'b0, 1'b1, 1'b1);
        check_hits("R9 m64 next window", 64'h0000_0012_3456_8000, 1'b0, 1'b1, 1'b1);
        check_hits("R9 io inside", 64'h0000_0000_0000_C0FF, 1'b1, 1'b1, 1'b1);
        check_hits("R9 io upper ignored", 64'hABCD_0000_0000_C0E0, 1'b1, 1'b1, 1'b1);
        check_hits("R7 io disabled", 64'h0000_0000_0000_C0E0, 1'b1, 1'b0, 1'b1);
        check_hits("R9 m32 inside", 64'h0000_0000_8001_FFFF, 1'b0, 1'b1, 1'b1);
        check_hits("R9 m32 above 4G", 64'h0000_0001_8001_0000, 1'b0, 1'b1, 1'b1);

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0) begin
                logic [2:0] s;
                logic [31:0] d;
                s = 3'($urandom % 6);
                d = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom;
                cfg_write(s, d);
                check_reads("R10 random");
            end else begin
                logic [63:0] a;
                int pick;
                pick = int'($urandom % 3);
                if (pick == 0)      a = {mb[63:12], 12'($urandom)};
                else if (pick == 1) a = {($urandom % 2 == 0) ? 32'd0 : $urandom, ib[31:5], 5'($urandom)};
                else                a = {($urandom % 4 == 0) ? $urandom : 32'd0, sb[31:16], 16'($urandom)};
                if ($urandom % 4 == 0) a = a ^ (64'd1 << ($urandom % 64));
                check_hits("R9 random", a, 1'($urandom), ($urandom % 5 != 0), ($urandom % 5 != 0));
            end
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule